// File: doc/BRIEF.md
# Scratchpad-to-Memory Destination-Chain DMA

This block moves 128-bit quadwords out of a 16 KiB on-chip scratchpad into main memory. In block mode, software supplies a scratchpad start address, a destination address and a quadword count. The controller copies that many quadwords and then stops.

In chain mode, the controller walks a list of descriptors stored in the scratchpad itself. At the current scratchpad address it reads one quadword and treats it as a descriptor. The descriptor holds the quadword count, a kind code, an interrupt-request bit and the main-memory destination. The payload follows the descriptor directly, and the next descriptor follows the payload. One descriptor kind, when the global stall-source selector names this channel, publishes a stall address. A draining channel uses that address so that it stays behind the data this channel has written. The chain ends on an end descriptor, or on a flagged descriptor when tag interrupts are enabled. At the end, the busy flag drops and a one-cycle completion interrupt is raised.

The scratchpad read port has one cycle of latency. The main-memory write port accepts one quadword per cycle.

Top module: `spad_dchain_dma`

## Requirements
- R1: After reset, `busy_o`, `done_irq_o`, `spad_rd_en_o` and `mem_wr_en_o` are 0 and `stall_addr_o` is 0. While `busy_o` is 0, no scratchpad read and no memory write is issued.
- R2: In block mode (`chain_mode_i`=0), a `go_i` pulse copies `blk_qwc_i` quadwords. They are read from ascending scratchpad addresses starting at `spad_start_i`. They are written to `blk_dst_i`, `blk_dst_i`+16, and so on, in order. Each write carries the data of the read issued one cycle before it.
- R3: Scratchpad addresses are 14-bit byte addresses. The low 4 bits of the start address are forced to 0. Address arithmetic wraps modulo 16 KiB, both while copying and while stepping from descriptor to descriptor.
- R4: In chain mode, a descriptor is the quadword at the current scratchpad address. Its fields are: bits 15:0 = count; bits 30:28 = kind; bit 31 = IRQ flag; bits 63:32 = destination address. Bits 27:16 and 127:64 are ignored. The payload starts 16 bytes after the descriptor. The next descriptor is read from the address just after the payload.
- R5: Kind 7 ends the chain after its payload. Every other kind continues with the next descriptor.
- R6: When `tag_irq_en_i` is 1 and the descriptor IRQ flag is 1, the chain ends after that descriptor's payload. With `tag_irq_en_i` at 0, the flag has no effect.
- R7: A kind-0 descriptor with `stall_src_i`=2 sets `stall_addr_o` to destination + 16×count (32-bit wrap). `stall_addr_o` is otherwise unchanged, including for kind-0 descriptors under any other `stall_src_i` value.
- R8: At the end of a transfer, `busy_o` falls and `done_irq_o` is 1 for exactly one cycle, in the same cycle. This happens once per transfer, after the last memory write.
- R9: A count of 0 copies nothing. Block mode then finishes, and chain mode proceeds to the next descriptor at descriptor address + 16.
- R10: A `go_i` pulse while `busy_o` is 1 is ignored and does not alter the write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start pulse (sets the channel running) |
| chain_mode_i | input | 1 | 0 = block mode, 1 = chain mode |
| tag_irq_en_i | input | 1 | Lets a descriptor IRQ flag end the chain |
| stall_src_i | input | 2 | Global stall-source selector; 2 selects this channel |
| blk_qwc_i | input | 16 | Block-mode quadword count |
| blk_dst_i | input | 32 | Block-mode destination byte address |
| spad_start_i | input | 14 | Scratchpad start byte address |
| spad_rd_en_o | output | 1 | Scratchpad read request |
| spad_rd_addr_o | output | 14 | Scratchpad read byte address |
| spad_rd_data_i | input | 128 | Scratchpad read data, one cycle after the request |
| mem_wr_en_o | output | 1 | Main-memory write strobe |
| mem_wr_addr_o | output | 32 | Main-memory write byte address |
| mem_wr_data_o | output | 128 | Main-memory write data |
| busy_o | output | 1 | Channel running |
| done_irq_o | output | 1 | One-cycle completion interrupt |
| stall_addr_o | output | 32 | Stall address register |

## Verification
The assertions assume that the scratchpad returns data exactly one cycle after each request. They also assume that `go_i` comes as a single-cycle pulse, and that destination addresses do not wrap within one descriptor's payload. The bench meets these assumptions as follows. Its scratchpad model is a plain registered read. It builds only quadword-aligned destinations drawn from the 32-bit space. It keeps payloads short enough that the chains it places never overlap themselves inside the 16 KiB scratchpad, even when a chain deliberately crosses the wrap point.

// File: rtl/spad_dchain_pkg.sv
package spad_dchain_pkg;

    localparam int QW_W        = 128;
    localparam int MEM_AW      = 32;
    localparam int CNT_W       = 16;
    localparam int KIND_W      = 3;
    localparam int STALL_SEL_W = 2;

    localparam logic [KIND_W-1:0]      KIND_STALL_CNT = 3'd0;
    localparam logic [KIND_W-1:0]      KIND_LAST      = 3'd7;
    localparam logic [STALL_SEL_W-1:0] STALL_SEL_SELF = 2'd2;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_DESC_RD,
        CTL_DESC_USE,
        CTL_COPY
    } ctl_state_e;

    typedef struct packed {
        logic [MEM_AW-1:0] dst;
        logic              irq;
        logic [KIND_W-1:0] kind;
        logic [11:0]       rsv;
        logic [CNT_W-1:0]  cnt;
    } desc_t;

    function automatic logic [MEM_AW-1:0] qw_span(input logic [CNT_W-1:0] cnt);
        return MEM_AW'({cnt, 4'b0000});
    endfunction

endpackage

// File: rtl/spad_desc_unpack.sv
module spad_desc_unpack
    import spad_dchain_pkg::*;
(
    input  logic [63:0] raw_i,
    input  logic        irq_en_i,
    output desc_t       desc_o,
    output logic        ends_chain_o
);
    logic unused_rsv;

    always_comb begin
        desc_o       = desc_t'(raw_i);
        ends_chain_o = (desc_o.kind == KIND_LAST) || (irq_en_i && desc_o.irq);
    end

    assign unused_rsv = ^desc_o.rsv;
endmodule

// File: rtl/spad_stall_reg.sv
module spad_stall_reg
    import spad_dchain_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_i,
    input  logic [STALL_SEL_W-1:0] sel_i,
    input  logic [KIND_W-1:0]      kind_i,
    input  logic [CNT_W-1:0]       cnt_i,
    input  logic [MEM_AW-1:0]      dst_i,
    output logic [MEM_AW-1:0]      stall_o
);
    logic take;

    assign take = load_i && (kind_i == KIND_STALL_CNT) && (sel_i == STALL_SEL_SELF);

    always_ff @(posedge clk) begin
        if (rst)
            stall_o <= '0;
        else if (take)
            stall_o <= dst_i + qw_span(cnt_i);
    end
endmodule

// File: rtl/spad_copy_engine.sv
module spad_copy_engine #(
    parameter int SPAD_AW = 14,
    parameter int MEM_AW  = 32,
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [SPAD_AW-1:0] src_i,
    input  logic [MEM_AW-1:0]  dst_i,
    output logic               rd_en_o,
    output logic [SPAD_AW-1:0] rd_addr_o,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               wr_en_o,
    output logic [MEM_AW-1:0]  wr_addr_o,
    output logic [DATA_W-1:0]  wr_data_o,
    output logic [SPAD_AW-1:0] src_next_o,
    output logic               done_o
);
    localparam int STEP = DATA_W / 8;

    logic               active_q;
    logic [CNT_W-1:0]   rem_q;
    logic [SPAD_AW-1:0] src_q;
    logic [MEM_AW-1:0]  dst_q;
    logic               pend_q;
    logic [MEM_AW-1:0]  waddr_q;

    assign rd_en_o    = active_q && (rem_q != '0);
    assign rd_addr_o  = src_q;
    assign done_o     = active_q && (rem_q == '0) && !pend_q;
    assign wr_en_o    = pend_q;
    assign wr_addr_o  = waddr_q;
    assign wr_data_o  = rd_data_i;
    assign src_next_o = src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            rem_q    <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            pend_q   <= 1'b0;
            waddr_q  <= '0;
        end else begin
            pend_q  <= rd_en_o;
            waddr_q <= dst_q;
            if (start_i) begin
                active_q <= 1'b1;
                rem_q    <= cnt_i;
                src_q    <= src_i;
                dst_q    <= dst_i;
            end else begin
                if (rd_en_o) begin
                    rem_q <= rem_q - CNT_W'(1);
                    src_q <= src_q + SPAD_AW'(STEP);
                    dst_q <= dst_q + MEM_AW'(STEP);
                end
                if (done_o)
                    active_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spad_dchain_dma.sv
module spad_dchain_dma
    import spad_dchain_pkg::*;
#(
    parameter int SPAD_AW = 14
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go_i,
    input  logic                   chain_mode_i,
    input  logic                   tag_irq_en_i,
    input  logic [STALL_SEL_W-1:0] stall_src_i,
    input  logic [CNT_W-1:0]       blk_qwc_i,
    input  logic [MEM_AW-1:0]      blk_dst_i,
    input  logic [SPAD_AW-1:0]     spad_start_i,
    output logic                   spad_rd_en_o,
    output logic [SPAD_AW-1:0]     spad_rd_addr_o,
    input  logic [QW_W-1:0]        spad_rd_data_i,
    output logic                   mem_wr_en_o,
    output logic [MEM_AW-1:0]      mem_wr_addr_o,
    output logic [QW_W-1:0]        mem_wr_data_o,
    output logic                   busy_o,
    output logic                   done_irq_o,
    output logic [MEM_AW-1:0]      stall_addr_o
);
    localparam int QW_BYTES = QW_W / 8;
    localparam int LSB_W    = $clog2(QW_BYTES);

    ctl_state_e         state_q;
    logic [SPAD_AW-1:0] sadr_q;
    logic               busy_q;
    logic               irq_q;
    logic               stop_after_q;

    desc_t              desc;
    logic               desc_ends;
    logic [SPAD_AW-1:0] start_al;

    logic               eng_start;
    logic [CNT_W-1:0]   eng_cnt;
    logic [SPAD_AW-1:0] eng_src;
    logic [MEM_AW-1:0]  eng_dst;
    logic               eng_rd_en;
    logic [SPAD_AW-1:0] eng_rd_addr;
    logic [SPAD_AW-1:0] eng_src_next;
    logic               eng_done;
    logic               desc_rd;

    assign start_al = {spad_start_i[SPAD_AW-1:LSB_W], LSB_W'(0)};

    spad_desc_unpack u_unpack (
        .raw_i        (spad_rd_data_i[63:0]),
        .irq_en_i     (tag_irq_en_i),
        .desc_o       (desc),
        .ends_chain_o (desc_ends)
    );

    always_comb begin
        eng_start = 1'b0;
        eng_cnt   = blk_qwc_i;
        eng_src   = start_al;
        eng_dst   = blk_dst_i;
        case (state_q)
            CTL_IDLE:     eng_start = go_i && !chain_mode_i;
            CTL_DESC_USE: begin
                eng_start = 1'b1;
                eng_cnt   = desc.cnt;
                eng_src   = sadr_q + SPAD_AW'(QW_BYTES);
                eng_dst   = desc.dst;
            end
            default: ;
        endcase
    end

    spad_copy_engine #(
        .SPAD_AW (SPAD_AW),
        .MEM_AW  (MEM_AW),
        .CNT_W   (CNT_W),
        .DATA_W  (QW_W)
    ) u_copy (
        .clk        (clk),
        .rst        (rst),
        .start_i    (eng_start),
        .cnt_i      (eng_cnt),
        .src_i      (eng_src),
        .dst_i      (eng_dst),
        .rd_en_o    (eng_rd_en),
        .rd_addr_o  (eng_rd_addr),
        .rd_data_i  (spad_rd_data_i),
        .wr_en_o    (mem_wr_en_o),
        .wr_addr_o  (mem_wr_addr_o),
        .wr_data_o  (mem_wr_data_o),
        .src_next_o (eng_src_next),
        .done_o     (eng_done)
    );

    spad_stall_reg u_stall (
        .clk     (clk),
        .rst     (rst),
        .load_i  (state_q == CTL_DESC_USE),
        .sel_i   (stall_src_i),
        .kind_i  (desc.kind),
        .cnt_i   (desc.cnt),
        .dst_i   (desc.dst),
        .stall_o (stall_addr_o)
    );

    assign desc_rd        = (state_q == CTL_DESC_RD);
    assign spad_rd_en_o   = desc_rd || eng_rd_en;
    assign spad_rd_addr_o = desc_rd ? sadr_q : eng_rd_addr;
    assign busy_o         = busy_q;
    assign done_irq_o     = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= CTL_IDLE;
            sadr_q       <= '0;
            busy_q       <= 1'b0;
            irq_q        <= 1'b0;
            stop_after_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state_q)
                CTL_IDLE: begin
                    if (go_i) begin
                        busy_q <= 1'b1;
                        sadr_q <= start_al;
                        if (chain_mode_i) begin
                            state_q <= CTL_DESC_RD;
                        end else begin
                            stop_after_q <= 1'b1;
                            state_q      <= CTL_COPY;
                        end
                    end
                end
                CTL_DESC_RD: state_q <= CTL_DESC_USE;
                CTL_DESC_USE: begin
                    stop_after_q <= desc_ends;
                    state_q      <= CTL_COPY;
                end
                CTL_COPY: begin
                    if (eng_done) begin
                        sadr_q <= eng_src_next;
                        if (stop_after_q) begin
                            busy_q  <= 1'b0;
                            irq_q   <= 1'b1;
                            state_q <= CTL_IDLE;
                        end else begin
                            state_q <= CTL_DESC_RD;
                        end
                    end
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spad_dchain_dma_chk.sv
module spad_dchain_dma_chk (
    input logic        clk,
    input logic        rst,
    input logic        spad_rd_en_o,
    input logic [13:0] spad_rd_addr_o,
    input logic        mem_wr_en_o,
    input logic [31:0] mem_wr_addr_o,
    input logic        busy_o,
    input logic        done_irq_o,
    input logic [31:0] stall_addr_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mem_wr_en_o && !spad_rd_en_o));

    // R2
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en_o |-> $past(spad_rd_en_o));

    // R2
    wr_stride_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en_o && $past(mem_wr_en_o)) |-> (mem_wr_addr_o == $past(mem_wr_addr_o) + 32'd16));

    // R3
    rd_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        spad_rd_en_o |-> (spad_rd_addr_o[3:0] == 4'd0));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(stall_addr_o) |-> $past(busy_o));

    // R8
    done_drops_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_irq_o |-> (!busy_o && $past(busy_o)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_irq_o |=> !done_irq_o);
endmodule

bind spad_dchain_dma spad_dchain_dma_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .spad_rd_en_o   (spad_rd_en_o),
    .spad_rd_addr_o (spad_rd_addr_o),
    .mem_wr_en_o    (mem_wr_en_o),
    .mem_wr_addr_o  (mem_wr_addr_o),
    .busy_o         (busy_o),
    .done_irq_o     (done_irq_o),
    .stall_addr_o   (stall_addr_o)
);

// File: tb/spad_dchain_dma_tb_top.sv
module spad_dchain_dma_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go = 1'b0;
    logic         chain = 1'b0;
    logic         tie = 1'b0;
    logic [1:0]   ss = 2'd0;
    logic [15:0]  qwc = '0;
    logic [31:0]  bdst = '0;
    logic [13:0]  sstart = '0;
    logic         rd_en;
    logic [13:0]  rd_addr;
    logic [127:0] rd_q = '0;
    logic         wr_en;
    logic [31:0]  wr_addr;
    logic [127:0] wr_data;
    logic         busy;
    logic         done_irq;
    logic [31:0]  stall_addr;

    logic [127:0] spad_mem [1024];
    logic [31:0]  exp_a[$];
    logic [127:0] exp_d[$];
    logic [31:0]  exp_stall = '0;
    string        cur_req = "R1";
    int           nchk = 0;
    int           nerr = 0;

    always #2 clk = ~clk;

    spad_dchain_dma dut_i (
        .clk(clk), .rst(rst), .go_i(go), .chain_mode_i(chain), .tag_irq_en_i(tie),
        .stall_src_i(ss), .blk_qwc_i(qwc), .blk_dst_i(bdst), .spad_start_i(sstart),
        .spad_rd_en_o(rd_en), .spad_rd_addr_o(rd_addr), .spad_rd_data_i(rd_q),
        .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
        .busy_o(busy), .done_irq_o(done_irq), .stall_addr_o(stall_addr)
    );

    always @(posedge clk) if (rd_en) rd_q <= spad_mem[rd_addr[13:4]];

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (exp_a.size() == 0) begin
                nchk++; nerr++;
                $display("FAIL %s unexpected write act=%h exp=none", cur_req, wr_addr);
            end else begin
                chk({cur_req, " write addr"}, 128'(wr_addr), 128'(exp_a.pop_front()));
                chk({cur_req, " write data"}, wr_data, exp_d.pop_front());
            end
        end
    end

    function automatic logic [127:0] rnd_qw();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic put_desc(input logic [13:0] a, input bit irq, input logic [2:0] kind,
                            input logic [15:0] cnt, input logic [31:0] dst);
        logic [127:0] q;
        q = rnd_qw();
        q[63:32] = dst; q[31] = irq; q[30:28] = kind; q[15:0] = cnt;
        spad_mem[a[13:4]] = q;
    endtask

    task automatic fill_payload(input logic [13:0] a, input int n);
        logic [13:0] p;
        p = a;
        for (int i = 0; i < n; i++) begin
            spad_mem[p[13:4]] = rnd_qw();
            p = p + 14'd16;
        end
    endtask

    // Expected writes for block mode (R2, R3)
    task automatic ref_block(input logic [13:0] st, input logic [15:0] n, input logic [31:0] d);
        logic [13:0] p;
        p = {st[13:4], 4'b0};
        for (int i = 0; i < int'(n); i++) begin
            exp_a.push_back(d + 32'(i) * 32'd16);
            exp_d.push_back(spad_mem[p[13:4]]);
            p = p + 14'd16;
        end
    endtask

    // Expected writes and stall address for chain mode (R4..R7, R9)
    task automatic ref_chain(input logic [13:0] st);
        logic [13:0]  p;
        logic [127:0] q;
        bit           fin;
        p = {st[13:4], 4'b0};
        fin = 0;
        for (int k = 0; k < 64 && !fin; k++) begin
            q = spad_mem[p[13:4]];
            if (q[30:28] == 3'd0 && ss == 2'd2)
                exp_stall = q[63:32] + {12'd0, q[15:0], 4'd0};
            p = p + 14'd16;
            for (int i = 0; i < int'(q[15:0]); i++) begin
                exp_a.push_back(q[63:32] + 32'(i) * 32'd16);
                exp_d.push_back(spad_mem[p[13:4]]);
                p = p + 14'd16;
            end
            fin = (q[30:28] == 3'd7) || (tie && q[31]);
        end
    endtask

    task automatic run_xfer(input string req, input bit extra_go);
        int cyc;
        cur_req = req;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        cyc = 0;
        while (!done_irq && cyc < 4000) begin
            go = (extra_go && (cyc == 2 || cyc == 5));
            @(negedge clk);
            cyc++;
        end
        go = 1'b0;
        if (cyc >= 4000) begin
            nchk++; nerr++;
            $display("FAIL %s R8 act=no completion exp=completion", req);
        end else begin
            chk({req, " R8 busy low at done"}, 128'(busy), 128'(0));
        end
        @(negedge clk);
        chk({req, " R8 single pulse"}, 128'(done_irq), 128'(0));
        chk({req, " R8 writes outstanding"}, 128'(exp_a.size()), 128'(0));
        chk({req, " R7 stall addr"}, 128'(stall_addr), 128'(exp_stall));
        exp_a.delete(); exp_d.delete();
        repeat (3) @(negedge clk);
    endtask

    task automatic rand_chain(input logic [13:0] st, input int ntag);
        logic [13:0] a;
        logic [15:0] c;
        logic [31:0] d;
        logic [2:0]  kind;
        a = st;
        for (int k = 0; k < ntag; k++) begin
            c = 16'($urandom_range(0, 5));
            d = $urandom(); d[3:0] = 4'd0;
            case ($urandom_range(0, 2))
                0: kind = 3'd0;
                1: kind = 3'd1;
                default: kind = 3'd3;
            endcase
            if (k == ntag - 1) kind = 3'd7;
            put_desc(a, ($urandom_range(0, 5) == 0), kind, c, d);
            fill_payload(a + 14'd16, int'(c));
            a = a + 14'd16 * (c[13:0] + 14'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) spad_mem[i] = rnd_qw();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 128'(busy), 128'(0));
        chk("R1 done", 128'(done_irq), 128'(0));
        chk("R1 wr_en", 128'(wr_en), 128'(0));
        chk("R1 rd_en", 128'(rd_en), 128'(0));
        chk("R1 stall", 128'(stall_addr), 128'(0));
        rst = 1'b0;
        @(negedge clk);

        // R2 block copy
        chain = 0; sstart = 14'h0200; qwc = 16'd5; bdst = 32'h1000_0000;
        ref_block(sstart, qwc, bdst);
        run_xfer("R2 block", 0);

        // R3 block copy across the scratchpad wrap, unaligned start
        sstart = 14'h3FD7; qwc = 16'd5; bdst = 32'h0000_8000;
        ref_block(sstart, qwc, bdst);
        run_xfer("R3 block wrap", 0);

        // R9 zero-count block
        sstart = 14'h0400; qwc = 16'd0;
        run_xfer("R9 block zero", 0);

        // R4 R5 R7 directed chain: kind1, kind0 with stall select, kind7
        chain = 1; tie = 0; ss = 2'd2; sstart = 14'h0100;
        put_desc(14'h0100, 0, 3'd1, 16'd2, 32'h1000_0000); fill_payload(14'h0110, 2);
        put_desc(14'h0130, 0, 3'd0, 16'd3, 32'h2000_0040); fill_payload(14'h0140, 3);
        put_desc(14'h0170, 0, 3'd7, 16'd1, 32'h3000_0000); fill_payload(14'h0180, 1);
        put_desc(14'h0190, 0, 3'd1, 16'd4, 32'h4000_0000);
        ref_chain(sstart);
        run_xfer("R4 R5 chain", 0);
        chk("R7 stall directed value", 128'(stall_addr), 128'(32'h2000_0070));

        // R7 kind0 with other stall select leaves stall address alone
        ss = 2'd1;
        ref_chain(sstart);
        run_xfer("R7 stall not selected", 0);
        chk("R7 stall kept", 128'(stall_addr), 128'(32'h2000_0070));

        // R3 R9 chain across wrap with zero-count end
        ss = 2'd2; sstart = 14'h3FE0;
        put_desc(14'h3FE0, 0, 3'd1, 16'd2, 32'h5000_0000); fill_payload(14'h3FF0, 2);
        put_desc(14'h0010, 0, 3'd7, 16'd0, 32'h6000_0000);
        ref_chain(sstart);
        run_xfer("R3 R9 chain wrap", 0);

        // R6 IRQ flag ends chain when enabled
        tie = 1; sstart = 14'h0800;
        put_desc(14'h0800, 1, 3'd1, 16'd1, 32'h7000_0000); fill_payload(14'h0810, 1);
        put_desc(14'h0820, 0, 3'd7, 16'd2, 32'h7100_0000); fill_payload(14'h0830, 2);
        ref_chain(sstart);
        run_xfer("R6 irq ends", 0);

        // R6 IRQ flag ignored when disabled
        tie = 0;
        ref_chain(sstart);
        run_xfer("R6 irq ignored", 0);

        // R10 extra start pulses while busy
        chain = 0; sstart = 14'h0A00; qwc = 16'd8; bdst = 32'h0800_0000;
        ref_block(sstart, qwc, bdst);
        run_xfer("R10 go while busy", 1);

        // Random mix of block and chain runs
        for (int t = 0; t < 40; t++) begin
            sstart = {$urandom_range(0, 1023), 4'b0};
            tie = 1'($urandom_range(0, 1));
            ss = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) begin
                chain = 0; qwc = 16'($urandom_range(0, 9));
                bdst = $urandom(); bdst[3:0] = 4'd0;
                fill_payload(sstart, int'(qwc));
                ref_block(sstart, qwc, bdst);
                run_xfer("R2 random block", 0);
            end else begin
                chain = 1;
                rand_chain(sstart, $urandom_range(1, 5));
                ref_chain(sstart);
                run_xfer("R4 R5 R6 R7 random chain", 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule